// File: doc/BRIEF.md
# Vectored Interrupt Controller with Qualified Clear

This block gathers single-cycle event strobes from up to 24 pipeline sources into a sticky status vector. It combines that vector with a mask and drives one interrupt line. The line acts either as a level (high while any unmasked status bit is set) or as a one-cycle pulse for each newly latched unmasked event. A second output, `err_o`, flags any unmasked status bit that belongs to the error class. Software reads the status vector back to find out which sources fired.

Clearing takes two steps. Software first loads a clear vector, then raises a qualifier bit and later lowers it. Only the rising edge of the qualifier removes the selected status bits, so the clear vector can be prepared ahead of time without effect. A per-source shadow-disable bit stops a source from latching: its event drives the interrupt line directly for the cycle in which it occurs. Position 10 is not a source.

Every register write, event and clear becomes visible at the outputs right after the clock edge that samples it. The one exception is the clear: it lands on the second edge after the qualifier write, because the edge of the qualifier is detected from its stored value.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `status_o` is 0, `irq_o` is 0 and `err_o` is 0. All sources reset masked, level mode is selected and no shadow bits are set.
- R2: An event on a valid source whose shadow bit is 0 sets status bit i at the next edge. The bit stays set until a qualified clear removes it.
- R3: Status bit 10 never becomes 1, even when `evt_i[10]` is pulsed.
- R4: In level mode (pulse-mode bit 0), `irq_o` equals the OR of status AND NOT mask. A mask bit of 1 suppresses its source. A mask write affects `irq_o` right after the edge that stores it.
- R5: Writing the clear vector alone changes nothing. Writing the qualifier to 1 clears the status bits selected by the clear vector at the second edge after that write. Holding the qualifier at 1 clears nothing more, and a new clear needs the qualifier to go back to 0 first.
- R6: If an event for a bit arrives in the same cycle that a qualified clear removes that bit, the bit stays set.
- R7: In pulse mode (pulse-mode bit 1), `irq_o` is high for exactly one cycle when an event newly sets an unmasked status bit. An event on a bit that is already set, or on a masked bit, gives no pulse.
- R8: An event on a source with its shadow bit set leaves the status bit unchanged. If that source is unmasked, `irq_o` goes high for one cycle per event cycle, in either mode.
- R9: `err_o` is 1 while any unmasked status bit at positions 2, 3, 19, 20 or 22 is set. Masked error bits and non-error bits do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 24 | One-cycle event strobes, one per source |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wd | input | 24 | Mask value, 1 = source suppressed |
| clrvec_we | input | 1 | Write strobe for the clear vector |
| clrvec_wd | input | 24 | Clear vector value, 1 = bit to clear |
| qual_we | input | 1 | Write strobe for the clear qualifier |
| qual_wd | input | 1 | Qualifier value; its rising edge applies the clear |
| shadow_we | input | 1 | Write strobe for the shadow-disable vector |
| shadow_wd | input | 24 | Shadow-disable value, 1 = source bypasses status |
| pmode_we | input | 1 | Write strobe for output mode |
| pmode_wd | input | 1 | 1 = pulse output, 0 = level output |
| status_o | output | 24 | Sticky status vector readback |
| irq_o | output | 1 | Interrupt output |
| err_o | output | 1 | Unmasked error-class status present |

## Verification
On every cycle the assertions check four things: each unshadowed event latches its status bit, a status bit falls only after a qualified clear that selects it, a shadowed event never sets its bit, and the clear strobe lasts one cycle and follows a qualifier write. They also check that level mode never hides an unmasked status bit and that `err_o` only rises with an error-class bit present. Some behaviour only the bench scenarios can show: that a clear vector write alone does nothing, that a held qualifier does not clear again, the exact timing of an event racing a clear, and that pulses are not repeated for bits already set or masked.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned SRC_COUNT = 24;
  // valid source positions: all except bit 10
  localparam logic [SRC_COUNT-1:0] SRC_PRESENT = 24'hFFFBFF;
  // error class: 2, 3, 19, 20, 22
  localparam logic [SRC_COUNT-1:0] SRC_ERRCLS = 24'h58000C;
endpackage

// File: rtl/ivc_rst_sync.sv
module ivc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ivc_cfg.sv
module ivc_cfg #(
  parameter int unsigned W = 24,
  parameter logic [W-1:0] MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  input  logic         clrvec_we,
  input  logic [W-1:0] clrvec_wd,
  input  logic         qual_we,
  input  logic         qual_wd,
  input  logic         shadow_we,
  input  logic [W-1:0] shadow_wd,
  input  logic         pmode_we,
  input  logic         pmode_wd,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] clrvec_q,
  output logic [W-1:0] shadow_q,
  output logic         pmode_q,
  output logic         clr_fire
);
  logic [W-1:0] mask_d, clrvec_d, shadow_d;
  logic         pmode_d, qual_q, qual_d, qual_dly_q;

  always_comb begin
    mask_d   = mask_q;
    clrvec_d = clrvec_q;
    shadow_d = shadow_q;
    pmode_d  = pmode_q;
    qual_d   = qual_q;
    if (mask_we)   mask_d   = mask_wd;
    if (clrvec_we) clrvec_d = clrvec_wd;
    if (shadow_we) shadow_d = shadow_wd;
    if (pmode_we)  pmode_d  = pmode_wd;
    if (qual_we)   qual_d   = qual_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= MASK_RST;
      clrvec_q   <= '0;
      shadow_q   <= '0;
      pmode_q    <= 1'b0;
      qual_q     <= 1'b0;
      qual_dly_q <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      clrvec_q   <= clrvec_d;
      shadow_q   <= shadow_d;
      pmode_q    <= pmode_d;
      qual_q     <= qual_d;
      qual_dly_q <= qual_q;
    end
  end

  // rising edge of the stored qualifier
  assign clr_fire = qual_q & ~qual_dly_q;

  p_fire_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> !clr_fire);
  p_fire_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |-> $past(qual_we && qual_wd));
endmodule

// File: rtl/ivc_status.sv
module ivc_status #(
  parameter int unsigned W = 24,
  parameter logic [W-1:0] PRESENT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] shadow_q,
  input  logic         clr_fire,
  input  logic [W-1:0] clrvec_q,
  output logic [W-1:0] set_vec,
  output logic [W-1:0] keep_vec,
  output logic [W-1:0] status_q
);
  logic [W-1:0] status_d;

  assign set_vec  = evt_i & PRESENT & ~shadow_q;
  assign keep_vec = status_q & ~(clr_fire ? clrvec_q : '0);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (PRESENT[i]) begin : g_src
      // event has priority over a clear in the same cycle
      always_comb status_d[i] = keep_vec[i] | set_vec[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= status_d[i];
      end

      p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[i] && !shadow_q[i]) |=> status_q[i]);
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_q[i]) |-> $past(clr_fire && clrvec_q[i]));
      p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[i] && shadow_q[i] && !status_q[i]) |=> !status_q[i]);
    end else begin : g_hole
      always_comb status_d[i] = 1'b0;
      always_comb status_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ivc_out.sv
module ivc_out #(
  parameter int unsigned W = 24,
  parameter logic [W-1:0] PRESENT = '1,
  parameter logic [W-1:0] ERRCLS  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] shadow_q,
  input  logic [W-1:0] mask_q,
  input  logic [W-1:0] status_q,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] keep_vec,
  input  logic         pmode_q,
  output logic         irq_o,
  output logic         err_o
);
  logic pulse_q, pulse_d, shad_q, shad_d, level;

  always_comb begin
    pulse_d = |(set_vec & ~keep_vec & ~mask_q);
    shad_d  = |(evt_i & shadow_q & PRESENT & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      shad_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      shad_q  <= shad_d;
    end
  end

  assign level = |(status_q & ~mask_q);
  assign irq_o = (pmode_q ? pulse_q : level) | shad_q;
  assign err_o = |(status_q & ~mask_q & ERRCLS);

  p_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pmode_q && |(status_q & ~mask_q)) |-> irq_o);
  p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> |(status_q & ERRCLS));
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(|set_vec));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_COUNT,
  parameter logic [NUM_SRC-1:0] PRESENT = SRC_PRESENT,
  parameter logic [NUM_SRC-1:0] ERRCLS  = SRC_ERRCLS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wd,
  input  logic               clrvec_we,
  input  logic [NUM_SRC-1:0] clrvec_wd,
  input  logic               qual_we,
  input  logic               qual_wd,
  input  logic               shadow_we,
  input  logic [NUM_SRC-1:0] shadow_wd,
  input  logic               pmode_we,
  input  logic               pmode_wd,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o,
  output logic               err_o
);
  logic               rst_s_n;
  logic [NUM_SRC-1:0] mask_q, clrvec_q, shadow_q, set_vec, keep_vec, status_q;
  logic               pmode_q, clr_fire;

  ivc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n)
  );

  ivc_cfg #(.W(NUM_SRC), .MASK_RST(PRESENT)) u_cfg (
    .clk(clk), .rst_n(rst_s_n),
    .mask_we(mask_we), .mask_wd(mask_wd),
    .clrvec_we(clrvec_we), .clrvec_wd(clrvec_wd),
    .qual_we(qual_we), .qual_wd(qual_wd),
    .shadow_we(shadow_we), .shadow_wd(shadow_wd),
    .pmode_we(pmode_we), .pmode_wd(pmode_wd),
    .mask_q(mask_q), .clrvec_q(clrvec_q), .shadow_q(shadow_q),
    .pmode_q(pmode_q), .clr_fire(clr_fire)
  );

  ivc_status #(.W(NUM_SRC), .PRESENT(PRESENT)) u_status (
    .clk(clk), .rst_n(rst_s_n), .evt_i(evt_i), .shadow_q(shadow_q),
    .clr_fire(clr_fire), .clrvec_q(clrvec_q),
    .set_vec(set_vec), .keep_vec(keep_vec), .status_q(status_q)
  );

  ivc_out #(.W(NUM_SRC), .PRESENT(PRESENT), .ERRCLS(ERRCLS)) u_out (
    .clk(clk), .rst_n(rst_s_n), .evt_i(evt_i), .shadow_q(shadow_q),
    .mask_q(mask_q), .status_q(status_q), .set_vec(set_vec),
    .keep_vec(keep_vec), .pmode_q(pmode_q), .irq_o(irq_o), .err_o(err_o)
  );

  assign status_o = status_q;

  p_hole_quiet_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    evt_i[10] |=> !status_o[10]);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] evt_i, mask_wd, clrvec_wd, shadow_wd, status_o;
  logic        mask_we, clrvec_we, qual_we, qual_wd, shadow_we, pmode_we, pmode_wd;
  logic        irq_o, err_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  string       q_req[$];
  logic [23:0] q_st[$];
  logic        q_irq[$], q_err[$];

  always #2 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .mask_we(mask_we), .mask_wd(mask_wd),
    .clrvec_we(clrvec_we), .clrvec_wd(clrvec_wd),
    .qual_we(qual_we), .qual_wd(qual_wd),
    .shadow_we(shadow_we), .shadow_wd(shadow_wd),
    .pmode_we(pmode_we), .pmode_wd(pmode_wd),
    .status_o(status_o), .irq_o(irq_o), .err_o(err_o)
  );

  task automatic idle_inputs();
    evt_i = '0; mask_we = 0; clrvec_we = 0; qual_we = 0;
    shadow_we = 0; pmode_we = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle_inputs();
  endtask

  task automatic expect_out(string req, logic [23:0] st, logic irq, logic err);
    q_req.push_back(req); q_st.push_back(st);
    q_irq.push_back(irq); q_err.push_back(err);
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q_req.size() > 0) begin
        string       r;
        logic [23:0] s;
        logic        ei, ee;
        r = q_req.pop_front(); s = q_st.pop_front();
        ei = q_irq.pop_front(); ee = q_err.pop_front();
        n_chk++;
        if (status_o !== s || irq_o !== ei || err_o !== ee) begin
          n_bad++;
          $display("FAIL %s: status=%h irq=%b err=%b expected status=%h irq=%b err=%b",
                   r, status_o, irq_o, err_o, s, ei, ee);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all reqs): actual=timeout expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mask_wd = '0; clrvec_wd = '0; shadow_wd = '0;
    qual_wd = 0; pmode_wd = 0; idle_inputs();
    repeat (3) @(posedge clk); #1; rst_n = 1;
    tick(); tick(); tick();
    expect_out("R1 reset", 24'h0, 0, 0);
    // R1: sources masked after reset
    evt_i = 24'h1; tick(); expect_out("R1 masked at reset", 24'h1, 0, 0);
    mask_we = 1; mask_wd = 24'h0; tick(); expect_out("R4 unmask", 24'h1, 1, 0);
    clrvec_we = 1; clrvec_wd = 24'h1; tick();
    qual_we = 1; qual_wd = 1; tick(); tick();
    qual_we = 1; qual_wd = 0; tick(); expect_out("R5 clear", 24'h0, 0, 0);

    evt_i = 24'h1; tick(); expect_out("R2 set", 24'h1, 1, 0);
    tick(); expect_out("R2 sticky", 24'h1, 1, 0);
    evt_i = 24'h400; tick(); expect_out("R3 hole bit", 24'h1, 1, 0);
    mask_we = 1; mask_wd = 24'h1; tick(); expect_out("R4 mask", 24'h1, 0, 0);
    evt_i = 24'h8; tick(); expect_out("R9 error set", 24'h9, 1, 1);
    mask_we = 1; mask_wd = 24'h9; tick(); expect_out("R9 error masked", 24'h9, 0, 0);
    mask_we = 1; mask_wd = 24'h0; tick(); expect_out("R9 error unmasked", 24'h9, 1, 1);
    evt_i = 24'h20; tick(); expect_out("R9 non-error", 24'h29, 1, 1);

    // R5: vector alone, then qualifier
    clrvec_we = 1; clrvec_wd = 24'h28; tick(); expect_out("R5 vector alone", 24'h29, 1, 1);
    qual_we = 1; qual_wd = 1; tick(); expect_out("R5 before fire", 24'h29, 1, 1);
    tick(); expect_out("R5 fire", 24'h1, 1, 0);
    evt_i = 24'h8; tick(); expect_out("R5 re-set", 24'h9, 1, 1);
    tick(); expect_out("R5 held qualifier", 24'h9, 1, 1);
    qual_we = 1; qual_wd = 0; tick(); expect_out("R5 qualifier low", 24'h9, 1, 1);

    // R6: event races clear
    clrvec_we = 1; clrvec_wd = 24'h9; tick();
    qual_we = 1; qual_wd = 1; tick();
    evt_i = 24'h1; tick(); expect_out("R6 event wins", 24'h1, 1, 0);
    qual_we = 1; qual_wd = 0; tick();
    clrvec_we = 1; clrvec_wd = 24'h1; tick();
    qual_we = 1; qual_wd = 1; tick(); tick(); expect_out("R5 clear all", 24'h0, 0, 0);
    qual_we = 1; qual_wd = 0; tick();

    // R7: pulse mode
    pmode_we = 1; pmode_wd = 1; tick(); expect_out("R7 mode", 24'h0, 0, 0);
    evt_i = 24'h2; tick(); expect_out("R7 pulse", 24'h2, 1, 0);
    tick(); expect_out("R7 one cycle", 24'h2, 0, 0);
    evt_i = 24'h2; tick(); expect_out("R7 already set", 24'h2, 0, 0);
    evt_i = 24'h10; tick(); expect_out("R7 second pulse", 24'h12, 1, 0);
    mask_we = 1; mask_wd = 24'h40; tick();
    evt_i = 24'h40; tick(); expect_out("R7 masked no pulse", 24'h52, 0, 0);

    // R8: shadow bypass
    shadow_we = 1; shadow_wd = 24'h80; tick();
    evt_i = 24'h80; tick(); expect_out("R8 pulse mode", 24'h52, 1, 0);
    tick(); expect_out("R8 one cycle", 24'h52, 0, 0);
    pmode_we = 1; pmode_wd = 0; mask_we = 1; mask_wd = 24'hFFFF7F; tick();
    expect_out("R4 level masked", 24'h52, 0, 0);
    evt_i = 24'h80; tick(); expect_out("R8 level mode", 24'h52, 1, 0);
    tick(); expect_out("R8 no latch", 24'h52, 0, 0);

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule